// File: doc/BRIEF.md
# Complementary Output Idle-State Controller

This block produces the two outputs of one channel with a complementary pair: a main output and its complement. While the master output enable is high, the main output follows the compare reference and the complement follows its inverse. Each output's rising edge is held back by a programmable dead-time, so the two are never high together. Each falling edge passes through at once.

When the master output enable drops, both outputs are first driven low. Once the dead-time has elapsed, each takes its own programmed idle level. The two idle-level bits sit in a small register with a write strobe. Any nonzero protection level makes that register ignore writes. All pins are plain control and status signals. There is no data stream, so no valid/ready handshake is involved.

All outputs are registered on the rising clock edge. An "edge that samples X" below means a rising edge at which input X holds the stated value. The dead-time `dt` is an unsigned count of clock cycles.

Top module: `cmp_idle_ctrl`

## Requirements
- R1: While `rst_n` is low, and at the first edge after reset, `out_main`, `out_comp`, `idle_main_q` and `idle_comp_q` are all 0.
- R2: With `moe`=1, once `ref_in` goes high, `out_main` rises at the (dt+1)th consecutive edge that samples `moe`=1 and `ref_in`=1. It falls after the first edge that samples `ref_in`=0 or `moe`=0 (except as R5/R6 allow).
- R3: With `moe`=1, `out_comp` behaves like R2 with `ref_in` inverted. It rises at the (dt+1)th consecutive edge that samples `moe`=1 and `ref_in`=0, and falls after the first edge that samples `ref_in`=1.
- R4: After any edge that samples `moe`=1, `out_main` and `out_comp` are not both high.
- R5: After `moe` drops, both outputs are 0 for the first dt edges that sample `moe`=0. From the (dt+1)th such edge on, they show the idle levels. With dt=0 the idle levels appear after the first such edge.
- R6: In the idle state, `out_main` is high exactly when idle bit `idle_main_q` is 1, and `out_comp` is high exactly when `idle_comp_q` is 1. A value of 0 gives a low output and 1 gives a high output.
- R7: An edge that samples `idle_wr_en`=1 while `lock_lvl` is 1, 2 or 3 leaves `idle_main_q` and `idle_comp_q` unchanged.
- R8: An edge that samples `idle_wr_en`=1 with `lock_lvl`=0 loads `idle_wr_main` and `idle_wr_comp` into the idle bits, visible after that edge. Idle-state outputs use the new values from the following edge on.
- R9: When `moe` rises again, the dead-time count restarts. An output whose reference level is already high rises at the (dt+1)th edge that samples `moe`=1.
- R10: The dead-time counters saturate rather than wrap, so the maximum dt of 255 gives a rise exactly 256 edges after the first qualifying edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_in | input | 1 | Compare reference level |
| moe | input | 1 | Master output enable |
| dt | input | DT_W (8) | Dead-time in clock cycles |
| lock_lvl | input | LOCK_W (2) | Protection level; nonzero blocks idle-bit writes |
| idle_wr_en | input | 1 | Write strobe for the idle bits |
| idle_wr_main | input | 1 | New idle level for the main output |
| idle_wr_comp | input | 1 | New idle level for the complementary output |
| out_main | output | 1 | Main output |
| out_comp | output | 1 | Complementary output |
| idle_main_q | output | 1 | Stored idle level, main output |
| idle_comp_q | output | 1 | Stored idle level, complementary output |

## Verification
A rising edge on an output is due dt+1 edges after the first edge that samples its qualifying condition. A falling edge is due one edge after the condition is removed. A write to the idle bits shows on the readback after one edge, and on the idle-state outputs after two. The bench drives inputs on the falling clock edge and steps a cycle model at each rising edge. It compares every output at the next falling edge, so each due cycle is checked exactly. The directed cases count edges until an output changes and compare that count with dt+1 or with 1.

// File: rtl/cmp_idle_pkg.sv
`timescale 1ns/1ps
package cmp_idle_pkg;

  // lane numbering for the dead-time counters
  localparam int unsigned LANE_MAIN = 0;
  localparam int unsigned LANE_COMP = 1;
  localparam int unsigned LANE_IDLE = 2;
  localparam int unsigned NUM_LANES = 3;

  typedef struct packed {
    logic main;
    logic comp;
  } idle_pair_t;

endpackage

// File: rtl/cic_rise_delay.sv
`timescale 1ns/1ps
// Holds back the assertion of a request until it has been seen for dt edges.
module cic_rise_delay #(
  parameter int unsigned DT_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [DT_W-1:0] dt,
  output logic            ok
);

  localparam logic [DT_W-1:0] CNT_MAX = {DT_W{1'b1}};

  logic [DT_W-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_cnt <= '0;
    end else if (!req) begin
      run_cnt <= '0;
    end else if (run_cnt != CNT_MAX) begin
      run_cnt <= run_cnt + DT_W'(1);
    end
  end

  assign ok = req && (run_cnt >= dt);

  // R2: a dropped request restarts the count
  p_run_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> run_cnt == '0);

  // R10: the count saturates and never wraps
  p_run_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req && run_cnt == CNT_MAX) |=> run_cnt == CNT_MAX);

endmodule

// File: rtl/cic_idle_bits.sv
`timescale 1ns/1ps
// Idle-level storage with write protection by lock level.
module cic_idle_bits
  import cmp_idle_pkg::*;
#(
  parameter int unsigned LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  idle_pair_t        wr_val,
  input  logic [LOCK_W-1:0] lock_lvl,
  output idle_pair_t        idle_q
);

  logic wr_open;
  assign wr_open = (lock_lvl == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q <= '0;
    end else if (wr_en && wr_open) begin
      idle_q <= wr_val;
    end
  end

  p_locked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_lvl != '0) |=> $stable(idle_q));

  p_open_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && lock_lvl == '0) |=> idle_q == $past(wr_val));

endmodule

// File: rtl/cic_out_stage.sv
`timescale 1ns/1ps
// Output registers: enabled lanes or gated idle levels.
module cic_out_stage
  import cmp_idle_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ok_main,
  input  logic       ok_comp,
  input  logic       ok_idle,
  input  idle_pair_t idle_q,
  output logic       out_main,
  output logic       out_comp
);

  logic nxt_main;
  logic nxt_comp;

  always_comb begin
    nxt_main = ok_main | (ok_idle & idle_q.main);
    nxt_comp = ok_comp | (ok_idle & idle_q.comp);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_main <= 1'b0;
      out_comp <= 1'b0;
    end else begin
      out_main <= nxt_main;
      out_comp <= nxt_comp;
    end
  end

  // R4: the enabled lanes are never granted together
  p_lane_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_main && ok_comp));

  // R5: idle levels are withheld until the idle lane has matured
  p_idle_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ok_main && !ok_comp && !ok_idle) |=> (!out_main && !out_comp));

endmodule

// File: rtl/cmp_idle_ctrl.sv
`timescale 1ns/1ps
module cmp_idle_ctrl
  import cmp_idle_pkg::*;
#(
  parameter int unsigned DT_W   = 8,
  parameter int unsigned LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_in,
  input  logic              moe,
  input  logic [DT_W-1:0]   dt,
  input  logic [LOCK_W-1:0] lock_lvl,
  input  logic              idle_wr_en,
  input  logic              idle_wr_main,
  input  logic              idle_wr_comp,
  output logic              out_main,
  output logic              out_comp,
  output logic              idle_main_q,
  output logic              idle_comp_q
);

  logic [NUM_LANES-1:0] lane_req;
  logic [NUM_LANES-1:0] lane_ok;
  idle_pair_t           wr_val;
  idle_pair_t           idle_q;

  always_comb begin
    lane_req[LANE_MAIN] = moe & ref_in;
    lane_req[LANE_COMP] = moe & ~ref_in;
    lane_req[LANE_IDLE] = ~moe;
    wr_val.main         = idle_wr_main;
    wr_val.comp         = idle_wr_comp;
  end

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    cic_rise_delay #(.DT_W(DT_W)) u_delay (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (lane_req[g]),
      .dt   (dt),
      .ok   (lane_ok[g])
    );
  end

  cic_idle_bits #(.LOCK_W(LOCK_W)) u_idle (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (idle_wr_en),
    .wr_val  (wr_val),
    .lock_lvl(lock_lvl),
    .idle_q  (idle_q)
  );

  cic_out_stage u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .ok_main (lane_ok[LANE_MAIN]),
    .ok_comp (lane_ok[LANE_COMP]),
    .ok_idle (lane_ok[LANE_IDLE]),
    .idle_q  (idle_q),
    .out_main(out_main),
    .out_comp(out_comp)
  );

  assign idle_main_q = idle_q.main;
  assign idle_comp_q = idle_q.comp;

  p_main_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (moe && !ref_in) |=> !out_main);

  p_comp_fall_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (moe && ref_in) |=> !out_comp);

  p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    moe |=> !(out_main && out_comp));

  p_idle_now_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!moe && dt == '0) |=> (out_main == $past(idle_main_q)) && (out_comp == $past(idle_comp_q)));

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (moe && dt == '0) |=> (out_main == $past(ref_in)) && (out_comp == !$past(ref_in)));

endmodule

// File: tb/cmp_idle_ctrl_bench.sv
`timescale 1ns/1ps
module cmp_idle_ctrl_bench;

  localparam int DT_W   = 8;
  localparam int LOCK_W = 2;
  localparam int WATCHDOG_CYC = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b0;
  logic moe = 1'b0;
  logic [DT_W-1:0] dt = '0;
  logic [LOCK_W-1:0] lock_lvl = '0;
  logic idle_wr_en = 1'b0;
  logic idle_wr_main = 1'b0;
  logic idle_wr_comp = 1'b0;
  logic out_main, out_comp, idle_main_q, idle_comp_q;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // cycle model state
  int   m_cnt [3];
  logic m_main = 1'b0, m_comp = 1'b0, m_im = 1'b0, m_ic = 1'b0;
  logic m_moe_at_edge = 1'b0;

  always #2.5 clk = ~clk;

  cmp_idle_ctrl #(.DT_W(DT_W), .LOCK_W(LOCK_W)) u_cmp_idle_ctrl (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .moe(moe), .dt(dt),
    .lock_lvl(lock_lvl), .idle_wr_en(idle_wr_en), .idle_wr_main(idle_wr_main),
    .idle_wr_comp(idle_wr_comp), .out_main(out_main), .out_comp(out_comp),
    .idle_main_q(idle_main_q), .idle_comp_q(idle_comp_q)
  );

  function automatic logic lane_ok(input logic req, input int cnt, input int d);
    return req && (cnt >= d);
  endfunction

  task automatic model_edge();
    logic [2:0] rq;
    logic [2:0] ok;
    if (!rst_n) begin
      for (int i = 0; i < 3; i++) m_cnt[i] = 0;
      m_main = 0; m_comp = 0; m_im = 0; m_ic = 0;
      m_moe_at_edge = 0;
      return;
    end
    rq[0] = moe & ref_in;
    rq[1] = moe & ~ref_in;
    rq[2] = ~moe;
    for (int i = 0; i < 3; i++) ok[i] = lane_ok(rq[i], m_cnt[i], int'(dt));
    m_main = ok[0] | (ok[2] & m_im);
    m_comp = ok[1] | (ok[2] & m_ic);
    for (int i = 0; i < 3; i++)
      m_cnt[i] = rq[i] ? ((m_cnt[i] == 255) ? 255 : m_cnt[i] + 1) : 0;
    if (idle_wr_en && lock_lvl == 0) begin
      m_im = idle_wr_main;
      m_ic = idle_wr_comp;
    end
    m_moe_at_edge = moe;
  endtask

  task automatic check(input string tag, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    if (!rst_n) begin
      check("R1 main in reset", out_main, 1'b0);
      check("R1 comp in reset", out_comp, 1'b0);
    end else if (m_moe_at_edge) begin
      check("R2 main enabled", out_main, m_main);
      check("R3 comp enabled", out_comp, m_comp);
    end else begin
      check("R5/R6 main idle", out_main, m_main);
      check("R5/R6 comp idle", out_comp, m_comp);
    end
    check("R7/R8 idle main bit", idle_main_q, m_im);
    check("R7/R8 idle comp bit", idle_comp_q, m_ic);
  endtask

  // count edges until an output reaches 1
  task automatic edges_to_high(input bit use_comp, output int n);
    n = 0;
    do begin
      step();
      n++;
    end while (((use_comp ? out_comp : out_main) != 1'b1) && n < 400);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog expired: actual hung expected done");
    finish_run();
  end

  initial begin
    int n;
    void'($urandom(32'h5eed_c1c0));
    for (int i = 0; i < 3; i++) m_cnt[i] = 0;
    @(negedge clk);
    repeat (3) step();
    rst_n = 1'b1;
    step();
    // R1: state right after reset
    check("R1 main after reset", out_main, 1'b0);
    check("R1 comp after reset", out_comp, 1'b0);
    check("R1 idle main after reset", idle_main_q, 1'b0);
    check("R1 idle comp after reset", idle_comp_q, 1'b0);

    // R8: open write, visible after one edge
    idle_wr_en = 1; idle_wr_main = 1; idle_wr_comp = 1; lock_lvl = 0;
    step();
    idle_wr_en = 0;
    check("R8 write main bit", idle_main_q, 1'b1);
    check("R8 write comp bit", idle_comp_q, 1'b1);

    // R7: locked writes ignored at every nonzero level
    for (int l = 1; l < 4; l++) begin
      lock_lvl = LOCK_W'(l);
      idle_wr_en = 1; idle_wr_main = 0; idle_wr_comp = 0;
      step();
      idle_wr_en = 0;
      check("R7 locked main bit", idle_main_q, 1'b1);
      check("R7 locked comp bit", idle_comp_q, 1'b1);
    end
    lock_lvl = 0;

    // R2: rise delay dt=4, then immediate fall
    dt = 4; moe = 1; ref_in = 0;
    repeat (8) step();
    ref_in = 1;
    edges_to_high(1'b0, n);
    check_int("R2 main rise delay dt=4", n, 5);
    check("R4 comp low while main high", out_comp, 1'b0);
    ref_in = 0;
    step();
    check("R2 main falls after one edge", out_main, 1'b0);
    // R3: complement rise after dead-time
    n = 1;
    while (out_comp != 1'b1 && n < 400) begin step(); n++; end
    check_int("R3 comp rise delay dt=4", n, 5);

    // R5/R6: moe drop with idle main=1, comp=1 and dt=3
    dt = 3; moe = 0;
    step();
    check("R5 main low during dead-time", out_main, 1'b0);
    check("R5 comp low during dead-time", out_comp, 1'b0);
    n = 1;
    while (out_main != 1'b1 && n < 400) begin step(); n++; end
    check_int("R5 idle after dt+1 edges", n, 4);
    check("R6 comp idle high", out_comp, 1'b1);

    // R8: new idle levels reach outputs one edge after readback
    idle_wr_en = 1; idle_wr_main = 0; idle_wr_comp = 1;
    step();
    idle_wr_en = 0;
    check("R8 outputs still old levels", out_main, 1'b1);
    step();
    check("R6 main idle now low", out_main, 1'b0);
    check("R6 comp idle still high", out_comp, 1'b1);

    // R9: re-enable with ref high, dt=2
    dt = 2; ref_in = 1; moe = 1;
    edges_to_high(1'b0, n);
    check_int("R9 re-enable rise delay", n, 3);

    // R10: maximum dead-time
    ref_in = 0; dt = 8'd255;
    step();
    ref_in = 1;
    edges_to_high(1'b0, n);
    check_int("R10 rise delay at dt=255", n, 256);
    ref_in = 0; dt = 0;
    step();

    // random segments checked against the cycle model
    for (int seg = 0; seg < 120; seg++) begin
      int len;
      case ($urandom % 4)
        0: dt = 0;
        1: dt = 1;
        2: dt = DT_W'($urandom % 4);
        default: dt = DT_W'($urandom % 12);
      endcase
      lock_lvl = LOCK_W'(($urandom % 3 == 0) ? ($urandom % 4) : 0);
      len = 10 + int'($urandom % 30);
      for (int c = 0; c < len; c++) begin
        if ($urandom % 5 == 0) ref_in = ~ref_in;
        if ($urandom % 17 == 0) moe = ~moe;
        idle_wr_en   = ($urandom % 9 == 0);
        idle_wr_main = $urandom % 2;
        idle_wr_comp = $urandom % 2;
        step();
      end
    end
    idle_wr_en = 0;
    finish_run();
  end

endmodule